// File: doc/BRIEF.md
# Cyclic Executive Frame Sequencer

This block is the hardware time-base for a cyclic executive. A clock divider cuts a free-running clock into minor frames, and eight minor frames form one major cycle. At the start of each minor frame a slot walker visits every task slot in ascending index order. A task is released when its rate group is due in the current frame. Each release is a single one-clock strobe. The walker then waits for that task to finish before it visits the next slot, so every task gets a fixed rate, a fixed position in the frame order and a predictable start time. Four rate groups are supported: every frame, every second frame, every fourth frame and once per major cycle. Each task has a phase, which spreads the slower groups across different frames.

A task ends its run with a one-clock done pulse. Every task has a cycle budget. A non-critical task that runs past its budget, or that is still running when the frame ends, is forced off by an abort strobe, and the walker moves on. A task marked critical is never cut: its overrun is only flagged, and it may run into the next frame. If a task is still busy when it is due again, the sequencer records an overlap and does not release it. Once every due task of the frame has been handled and none is still running, the background-enable output opens a window for low-priority work such as continuous built-in test.

Top module: `frame_sequencer`

## Requirements
- R1: The frame index is 3 bits wide. It advances by one, wrapping from 7 to 0, exactly every FRAME_CYC clock cycles. The first frame after reset is frame 0 and lasts FRAME_CYC cycles.
- R2: `major_tick` is high for exactly one clock: the first cycle of frame 0 after a wrap from frame 7. It stays low out of reset and in all other cycles.
- R3: Task i has a 2-bit rate code at TASK_RATE bits [2i+1:2i] and a 3-bit phase at TASK_PHASE bits [3i+2:3i]. With r as the rate code, the task is due in frame f when f mod 2^r equals phase mod 2^r, and it is released exactly once in each frame where it is due and idle.
- R4: Within a frame, releases occur in strictly ascending task index. Task 0, when due and idle, is released in the second clock of the frame, which is one cycle after the frame index changes.
- R5: Each release strobe lasts one clock, and at most one strobe is high at a time. The next slot is not visited until the released task has finished or been aborted.
- R6: A done pulse ends a busy task. A done pulse on a task that is not busy has no effect.
- R7: A non-critical task that is still busy after TASK_BUDGET cycles sets its sticky overrun flag. The first busy cycle is its release cycle. Its abort strobe is high exactly TASK_BUDGET cycles after its release strobe, and the walker then continues with the next slot in the same frame.
- R8: A critical task (task_crit bit high) that exceeds its budget sets its overrun flag but receives no abort, and the walker keeps waiting for it.
- R9: At the last cycle of a frame, a busy non-critical task is aborted and flagged as overrun, with the abort strobe in the first cycle of the next frame. A busy critical task is not aborted. The walker always restarts at slot 0 in the new frame.
- R10: A task that is due while still busy is not released. Instead it sets its sticky overlap flag.
- R11: `bg_en` is high only when all due tasks of the frame have been handled, no task is busy and no release is in progress. It is always low in the last cycle of each frame.
- R12: While reset is held and right after it, all strobes, flags, `major_tick` and `bg_en` are low and the frame index is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low synchronous reset |
| task_done | input | N_TASK | One-clock completion pulse per task |
| task_crit | input | N_TASK | High marks the task as critical (never aborted) |
| task_rel | output | N_TASK | One-clock release strobe per task |
| task_abort | output | N_TASK | One-clock forced-stop strobe per task |
| frame_idx | output | 3 | Current minor frame number 0..7 |
| major_tick | output | 1 | Strobe at the start of each new major cycle |
| bg_en | output | 1 | Background work window |
| overrun | output | N_TASK | Sticky per-task budget or frame overrun flag |
| overlap | output | N_TASK | Sticky per-task re-release-while-busy flag |

## Verification
The bench builds the block with a 64-cycle frame and five tasks. Their rate codes are 0, 1, 0, 2 and 3, with phases 0, 0, 0, 1 and 2. Their budgets are 4, 6, 6, 6 and 100. With a 512-cycle major cycle, a sweep of two full major cycles covers every frame and every rate-phase combination, and the bench compares each frame against the release set and order it computes. The 6-cycle budget is short enough to test budget pre-emption within a frame. The budget of 100 on the once-per-major task is longer than a frame, so that task can only be stopped at the frame boundary. Declaring the every-other-frame task critical and never completing it brings critical run-on and the overlap case within reach.

// File: rtl/fseq_pkg.sv
`timescale 1ns/1ps
package fseq_pkg;
  localparam int FIDX_W = 3;
  localparam int FRAMES_PER_MAJOR = 1 << FIDX_W;
  typedef logic [FIDX_W-1:0] fidx_t;
  typedef enum logic {WALK_SCAN, WALK_WAIT} walk_st_e;
endpackage

// File: rtl/fseq_timer.sv
`timescale 1ns/1ps
module fseq_timer
  import fseq_pkg::*;
#(
  parameter int FRAME_CYC = 2000000
) (
  input  logic  clk,
  input  logic  rst_n,
  output fidx_t frame_idx,
  output logic  frame_last,
  output logic  major
);
  localparam int CW = (FRAME_CYC < 2) ? 1 : $clog2(FRAME_CYC);
  localparam logic [CW-1:0] LAST = CW'(FRAME_CYC - 1);

  logic [CW-1:0] cnt;

  assign frame_last = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      frame_idx <= '0;
      major     <= 1'b0;
    end else begin
      major <= 1'b0;
      if (frame_last) begin
        cnt       <= '0;
        frame_idx <= frame_idx + fidx_t'(1);
        major     <= (frame_idx == fidx_t'(FRAMES_PER_MAJOR - 1));
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R1: the index moves by one at each frame boundary and holds otherwise
  a_r1_frame_advance: assert property (@(posedge clk) disable iff (!rst_n)
    frame_last |=> frame_idx == $past(frame_idx) + fidx_t'(1));
  a_r1_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_last |=> $stable(frame_idx));
  // R2: the major strobe only appears in frame 0
  a_r2_major_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    major |-> frame_idx == '0);
endmodule

// File: rtl/fseq_due.sv
`timescale 1ns/1ps
module fseq_due
  import fseq_pkg::*;
#(
  parameter int N_TASK = 5,
  parameter logic [2*N_TASK-1:0] TASK_RATE  = '0,
  parameter logic [3*N_TASK-1:0] TASK_PHASE = '0
) (
  input  fidx_t             frame_idx,
  output logic [N_TASK-1:0] due
);
  for (genvar i = 0; i < N_TASK; i++) begin : g_slot
    localparam int    RCODE = int'(TASK_RATE[2*i +: 2]);
    localparam fidx_t MASK  = fidx_t'((1 << RCODE) - 1);
    localparam fidx_t PHASE = fidx_t'(TASK_PHASE[3*i +: 3]);
    assign due[i] = ((frame_idx ^ PHASE) & MASK) == '0;
  end
endmodule

// File: rtl/fseq_task_mon.sv
`timescale 1ns/1ps
module fseq_task_mon #(
  parameter int BUDGET = 60000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic done,
  input  logic crit,
  input  logic boundary,
  output logic busy,
  output logic abort,
  output logic ovr
);
  localparam int BW = (BUDGET < 2) ? 1 : $clog2(BUDGET);
  localparam logic [BW-1:0] LIMIT = BW'(BUDGET - 1);

  logic [BW-1:0] used;
  logic          expire;

  assign expire = busy && !done && (used == LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      abort <= 1'b0;
      ovr   <= 1'b0;
      used  <= '0;
    end else begin
      abort <= 1'b0;
      if (launch) begin
        busy <= 1'b1;
        used <= '0;
      end else if (busy) begin
        if (done) begin
          busy <= 1'b0;
        end else if (boundary || expire) begin
          ovr <= 1'b1;
          if (!crit) begin
            busy  <= 1'b0;
            abort <= 1'b1;
          end
        end else begin
          used <= used + BW'(1);
        end
      end
    end
  end

  // R7: an abort only follows a flagged overrun and leaves the slot idle
  a_r7_abort_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (!busy && ovr));
  // R6: a done pulse on a busy task ends it
  a_r6_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done && !launch) |=> !busy);
  // R8: a critical task is never cut
  a_r8_crit_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && crit && !done && !launch) |=> busy);
endmodule

// File: rtl/fseq_walker.sv
`timescale 1ns/1ps
module fseq_walker
  import fseq_pkg::*;
#(
  parameter int N_TASK = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TASK-1:0] due,
  input  logic [N_TASK-1:0] busy,
  input  logic              boundary,
  output logic [N_TASK-1:0] launch,
  output logic [N_TASK-1:0] rel,
  output logic [N_TASK-1:0] ovl,
  output logic              walk_end
);
  localparam int PW = $clog2(N_TASK + 1);
  localparam int IW = (N_TASK < 2) ? 1 : $clog2(N_TASK);

  logic [PW-1:0] ptr;
  logic [IW-1:0] idx;
  walk_st_e      st;
  logic          cur_due, cur_busy, go;

  assign walk_end = (ptr == PW'(N_TASK));
  assign idx      = ptr[IW-1:0];
  assign cur_due  = !walk_end && due[idx];
  assign cur_busy = !walk_end && busy[idx];
  assign go       = !boundary && (st == WALK_SCAN) && cur_due && !cur_busy;
  assign launch   = go ? (N_TASK'(1) << idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      st  <= WALK_SCAN;
      rel <= '0;
      ovl <= '0;
    end else begin
      rel <= launch;
      if (boundary) begin
        ptr <= '0;
        st  <= WALK_SCAN;
      end else begin
        case (st)
          WALK_SCAN: begin
            if (!walk_end) begin
              if (go) begin
                st <= WALK_WAIT;
              end else begin
                if (cur_due) ovl[idx] <= 1'b1;
                ptr <= ptr + PW'(1);
              end
            end
          end
          WALK_WAIT: begin
            if (!cur_busy) begin
              st  <= WALK_SCAN;
              ptr <= ptr + PW'(1);
            end
          end
          default: st <= WALK_SCAN;
        endcase
      end
    end
  end

  // R5: one strobe at a time
  a_r5_single_release: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rel));
  // R4: slots are visited in ascending order inside a frame
  a_r4_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> ptr >= $past(ptr));
  // R3: only due tasks are released
  a_r3_release_due: assert property (@(posedge clk) disable iff (!rst_n)
    (rel & ~$past(due)) == '0);
endmodule

// File: rtl/frame_sequencer.sv
`timescale 1ns/1ps
module frame_sequencer
  import fseq_pkg::*;
#(
  parameter int N_TASK    = 5,
  parameter int FRAME_CYC = 2000000,
  parameter logic [2*N_TASK-1:0]  TASK_RATE   = {2'd3, 2'd2, 2'd0, 2'd1, 2'd0},
  parameter logic [3*N_TASK-1:0]  TASK_PHASE  = {3'd2, 3'd1, 3'd0, 3'd0, 3'd0},
  parameter logic [16*N_TASK-1:0] TASK_BUDGET = {16'd60000, 16'd40000, 16'd40000,
                                                 16'd40000, 16'd20000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TASK-1:0] task_done,
  input  logic [N_TASK-1:0] task_crit,
  output logic [N_TASK-1:0] task_rel,
  output logic [N_TASK-1:0] task_abort,
  output fidx_t             frame_idx,
  output logic              major_tick,
  output logic              bg_en,
  output logic [N_TASK-1:0] overrun,
  output logic [N_TASK-1:0] overlap
);
  logic              frame_last;
  logic              walk_end;
  logic [N_TASK-1:0] due_vec, busy_vec, launch_vec;

  fseq_timer #(.FRAME_CYC(FRAME_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .frame_idx(frame_idx),
    .frame_last(frame_last), .major(major_tick)
  );

  fseq_due #(.N_TASK(N_TASK), .TASK_RATE(TASK_RATE), .TASK_PHASE(TASK_PHASE)) u_due (
    .frame_idx(frame_idx), .due(due_vec)
  );

  fseq_walker #(.N_TASK(N_TASK)) u_walker (
    .clk(clk), .rst_n(rst_n), .due(due_vec), .busy(busy_vec),
    .boundary(frame_last), .launch(launch_vec), .rel(task_rel),
    .ovl(overlap), .walk_end(walk_end)
  );

  for (genvar i = 0; i < N_TASK; i++) begin : g_mon
    fseq_task_mon #(.BUDGET(int'(TASK_BUDGET[16*i +: 16]))) u_mon (
      .clk(clk), .rst_n(rst_n), .launch(launch_vec[i]), .done(task_done[i]),
      .crit(task_crit[i]), .boundary(frame_last), .busy(busy_vec[i]),
      .abort(task_abort[i]), .ovr(overrun[i])
    );
  end

  assign bg_en = walk_end && (busy_vec == '0) && !frame_last;

  // R11: no release or abort happens inside the background window
  a_r11_bg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    bg_en |-> ((task_rel == '0) && (task_abort == '0)));
  // R10: a task busy in the previous cycle is never released again
  a_r10_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
    (task_rel & $past(busy_vec)) == '0);
endmodule

// File: tb/test_frame_sequencer.sv
`timescale 1ns/1ps
module test_frame_sequencer;
  localparam int N  = 5;
  localparam int FC = 64;
  localparam logic [2*N-1:0]  RATE = {2'd3, 2'd2, 2'd0, 2'd1, 2'd0};
  localparam logic [3*N-1:0]  PH   = {3'd2, 3'd1, 3'd0, 3'd0, 3'd0};
  localparam logic [16*N-1:0] BUD  = {16'd100, 16'd6, 16'd6, 16'd6, 16'd4};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] task_done = '0;
  logic [N-1:0] task_crit = '0;
  logic [N-1:0] task_rel, task_abort, overrun, overlap;
  logic [2:0]   frame_idx;
  logic         major_tick, bg_en;

  always #5 clk = ~clk;

  frame_sequencer #(.N_TASK(N), .FRAME_CYC(FC), .TASK_RATE(RATE),
                    .TASK_PHASE(PH), .TASK_BUDGET(BUD)) i_frame_sequencer (
    .clk(clk), .rst_n(rst_n), .task_done(task_done), .task_crit(task_crit),
    .task_rel(task_rel), .task_abort(task_abort), .frame_idx(frame_idx),
    .major_tick(major_tick), .bg_en(bg_en), .overrun(overrun), .overlap(overlap)
  );

  int total = 0, bad = 0;
  int lat[N], rcnt[N];
  bit outst[N];
  int rel_cnt[N], abort_cnt[N], first_rel_off[N], first_rel_frame[N];
  int abort_off[N], abort_frame[N];
  int off, prev_f, frames_done, seen, last_rel, t0_off, bg_cnt;
  bit chk_frames, v_order, v_ovl, v_bg, v_major, bg_seen;
  int spur_i, spur_f, spur_off;

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int due_mask(int f);
    int m = 0;
    for (int i = 0; i < N; i++) begin
      int r = int'(RATE[2*i +: 2]);
      int p = int'(PH[3*i +: 3]);
      int k = (1 << r) - 1;
      if ((f & k) == (p & k)) m |= (1 << i);
    end
    return m;
  endfunction

  function automatic bit any_out();
    bit a = 0;
    for (int i = 0; i < N; i++) a |= outst[i];
    return a;
  endfunction

  task automatic clear_frame();
    seen = 0; last_rel = -1; t0_off = -1;
    v_order = 0; v_ovl = 0; v_bg = 0; v_major = 0; bg_seen = 0;
  endtask

  task automatic step();
    logic [N-1:0] d;
    @(negedge clk);
    if (int'(frame_idx) != prev_f) begin
      if (chk_frames) begin
        check(off == FC - 1, "R1", "frame length", off + 1, FC);
        check(int'(frame_idx) == ((prev_f + 1) % 8), "R1", "index step",
              int'(frame_idx), (prev_f + 1) % 8);
        check(major_tick == (frame_idx == 3'd0) && !v_major, "R2", "major strobe",
              int'(major_tick), int'(frame_idx == 3'd0));
        check(seen == due_mask(prev_f), "R3", "released set", seen, due_mask(prev_f));
        check(t0_off == 1, "R4", "task 0 release offset", t0_off, 1);
        check(!v_order, "R4", "ascending order", int'(v_order), 0);
        check(!v_ovl, "R5", "release while another runs", int'(v_ovl), 0);
        check(bg_seen && !v_bg, "R11", "background window", int'(v_bg), 0);
      end
      frames_done++;
      off = 0;
      prev_f = int'(frame_idx);
      clear_frame();
    end else begin
      off++;
      if (major_tick) v_major = 1;
    end
    if (off == FC - 1 && bg_en) v_bg = 1;
    if (bg_en) begin
      bg_seen = 1; bg_cnt++;
      if (task_rel != '0 || any_out()) v_bg = 1;
    end
    for (int i = 0; i < N; i++) begin
      if (task_rel[i]) begin
        if (any_out()) v_ovl = 1;
        if (i <= last_rel) v_order = 1;
        last_rel = i;
        if (i == 0) t0_off = off;
        seen |= (1 << i);
        rel_cnt[i]++;
        if (first_rel_off[i] < 0) begin
          first_rel_off[i] = off; first_rel_frame[i] = frames_done;
        end
        outst[i] = 1; rcnt[i] = lat[i];
      end
      if (task_abort[i]) begin
        abort_cnt[i]++;
        if (abort_frame[i] < 0) begin
          abort_frame[i] = frames_done; abort_off[i] = off;
        end
        outst[i] = 0;
      end
    end
    d = '0;
    for (int i = 0; i < N; i++) begin
      if (outst[i] && lat[i] != 0) begin
        if (rcnt[i] <= 1) begin d[i] = 1'b1; outst[i] = 0; end
        else rcnt[i]--;
      end
    end
    if (spur_i >= 0 && frames_done == spur_f && off == spur_off) d[spur_i] = 1'b1;
    task_done = d;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    task_done = '0;
    for (int i = 0; i < N; i++) begin
      rcnt[i] = 0; outst[i] = 0; rel_cnt[i] = 0; abort_cnt[i] = 0;
      first_rel_off[i] = -1; first_rel_frame[i] = -1;
      abort_off[i] = -1; abort_frame[i] = -1;
    end
    spur_i = -1; bg_cnt = 0; chk_frames = 0;
    repeat (3) @(negedge clk);
    check(task_rel == '0 && task_abort == '0, "R12", "strobes in reset",
          int'(task_rel | task_abort), 0);
    check(overrun == '0 && overlap == '0, "R12", "flags in reset",
          int'(overrun | overlap), 0);
    check(frame_idx == 3'd0 && !major_tick && !bg_en, "R12", "index/major/bg in reset",
          int'(frame_idx), 0);
    rst_n = 1'b1;
    off = 0; prev_f = 0; frames_done = 0;
    clear_frame();
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog run hung actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // Sweep: two major cycles, all tasks finish in two cycles
    for (int i = 0; i < N; i++) lat[i] = 2;
    task_crit = 5'b00001;
    do_reset();
    chk_frames = 1;
    spur_i = 3; spur_f = 0; spur_off = 40;   // R6: done on an idle task
    repeat (16 * FC) step();
    chk_frames = 0;
    check(rel_cnt[0] == 16, "R3", "rate code 0 count", rel_cnt[0], 16);
    check(rel_cnt[1] == 8,  "R3", "rate code 1 count", rel_cnt[1], 8);
    check(rel_cnt[2] == 16, "R3", "rate code 0 count task 2", rel_cnt[2], 16);
    check(rel_cnt[3] == 4,  "R3", "rate code 2 count", rel_cnt[3], 4);
    check(rel_cnt[4] == 2,  "R3", "rate code 3 count", rel_cnt[4], 2);
    check(first_rel_frame[3] == 1, "R6", "idle done left task 3 schedule",
          first_rel_frame[3], 1);
    check(overrun == '0, "R6", "no overrun with timely done", int'(overrun), 0);
    check(overlap == '0, "R10", "no overlap with timely done", int'(overlap), 0);

    // Non-critical budget and boundary pre-emption
    lat[1] = 0; lat[4] = 0; task_crit = '0;
    do_reset();
    repeat (4 * FC) step();
    check(abort_frame[1] == 0 && abort_off[1] - first_rel_off[1] == 6, "R7",
          "abort delay after release", abort_off[1] - first_rel_off[1], 6);
    check(overrun[1], "R7", "budget overrun flag", int'(overrun[1]), 1);
    check(abort_cnt[1] == 2, "R7", "aborts of task 1", abort_cnt[1], 2);
    check(rel_cnt[2] == 4, "R7", "walker continues after abort", rel_cnt[2], 4);
    check(abort_frame[4] == 3 && abort_off[4] == 0, "R9", "boundary abort timing",
          abort_frame[4] * 100 + abort_off[4], 300);
    check(overrun[4] && abort_cnt[4] == 1, "R9", "boundary overrun",
          int'(overrun[4]), 1);
    check(overlap == '0, "R10", "aborted tasks never overlap", int'(overlap), 0);

    // Critical task that never finishes
    for (int i = 0; i < N; i++) lat[i] = 2;
    lat[1] = 0; task_crit = 5'b00010;
    do_reset();
    repeat (3 * FC) step();
    check(overrun[1], "R8", "critical overrun flag", int'(overrun[1]), 1);
    check(abort_cnt[1] == 0, "R8", "critical never aborted", abort_cnt[1], 0);
    check(first_rel_frame[2] == 1, "R5", "walker waits on critical task",
          first_rel_frame[2], 1);
    check(rel_cnt[0] == 3, "R9", "walker restarts each frame", rel_cnt[0], 3);
    check(overlap == 5'b00010, "R10", "overlap flag", int'(overlap), 2);
    check(rel_cnt[1] == 1, "R10", "no re-release while busy", rel_cnt[1], 1);
    check(bg_cnt == 0, "R11", "no background while busy", bg_cnt, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule